// File: doc/BRIEF.md
# Serial EEPROM Status Write-Protection Controller

This block is the protection decision logic on the command side of a serial memory slave with an SPI front end. It owns the status byte: the busy flag for an internal program cycle, the write-enable latch, a two-bit block-protect code and a protect-enable bit. Decoded single-cycle command strobes arrive from the command decoder:

- enable writes
- disable writes
- write status, with its data byte
- array write, with its target address
- read status

The block answers each array write and each status write with a one-cycle grant or block pulse. A granted write starts the busy period. The timer that runs the program cycle reports its end with a done pulse. That pulse commits any pending status value and clears both the busy flag and the latch.

The parameter `SMALL_DEV` selects how the active-low write-protect pin works:

- **Small-device scheme (`SMALL_DEV`=1):** a low pin wipes the latch and pins it at zero.
- **Large-device scheme (`SMALL_DEV`=0):** the pin matters only while protect-enable is 1. Even then it only refuses status writes.

When several strobes arrive together, one wins in this order: array write, then status write, then disable, then enable. A read-status strobe is independent of the others.

Top module: `eewp_ctrl`

## Requirements
- R1: After reset, `status_o`, `rd_status_o` and all four decision pulses are 0. The status byte is laid out as follows:
  - bit 0 is the busy flag
  - bit 1 is the write-enable latch
  - bits 3:2 are the block-protect code
  - bit 7 is protect-enable
  - bits 6:4 read 0
- R2: An enable-writes strobe sets the latch one cycle later, provided the block is not busy. In the small-device scheme, the pin must also be high.
- R3: An array write or status write that finds the latch clear draws a block pulse one cycle later and changes no status bit.
- R4: Block-protect code 0 protects nothing. Code 1 protects addresses whose top two bits are 11, code 2 protects addresses whose top bit is 1, and code 3 protects every address. An array write with the latch set that targets a protected address draws `arr_block_o` and leaves the latch set.
- R5: An accepted array write draws `arr_grant_o`, sets the busy flag and keeps the latch set. Both stay set until a done pulse, and the cycle after that pulse both read 0.
- R6: An accepted status write draws `sr_grant_o` and sets the busy flag. The new block-protect code and protect-enable take effect only at the done pulse. Data bits 6:4 and 1:0 are ignored.
- R7: A disable-writes strobe while idle clears the latch one cycle later.
- R8: While the busy flag is set:
  - enable and disable strobes change nothing
  - array and status writes draw a block pulse and change nothing
  - the status byte stays readable
- R9: In the small-device scheme, a low pin clears the latch within one cycle and keeps it clear. Raising the pin does not set it again. Protect-enable always reads 0.
- R10: In the large-device scheme, a status write with the latch set is blocked when protect-enable is 1 and the pin is low, and the latch stays set. With protect-enable at 0 the pin has no effect. The pin never affects array writes or the latch.
- R11: A done pulse while idle changes no status bit.
- R12: A read-status strobe loads `rd_status_o`, one cycle later, with the status byte as it stood at the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| cmd_wren_i | input | 1 | Enable-writes strobe |
| cmd_wrdi_i | input | 1 | Disable-writes strobe |
| cmd_wrsr_i | input | 1 | Write-status strobe |
| sr_wdata_i | input | 8 | Data byte of a status write |
| cmd_write_i | input | 1 | Array-write strobe |
| wr_addr_i | input | ADDR_W | Target address of an array write |
| cmd_rdsr_i | input | 1 | Read-status strobe |
| wp_ni | input | 1 | Write-protect pin, active low |
| wcyc_done_i | input | 1 | End-of-program-cycle pulse |
| status_o | output | 8 | Live status byte |
| rd_status_o | output | 8 | Status byte captured on read-status |
| arr_grant_o | output | 1 | Array write accepted (pulse) |
| arr_block_o | output | 1 | Array write refused (pulse) |
| sr_grant_o | output | 1 | Status write accepted (pulse) |
| sr_block_o | output | 1 | Status write refused (pulse) |

## Verification
Both schemes are instantiated side by side with a 6-bit address. The main protection decision is swept over every block-protect code against every address. Each grant or block is compared with a region test computed arithmetically, so an off-by-one boundary in the quarter or half decode shows up.

Further patterns separate the remaining behaviour:
- **Latch clear:** writes with the latch clear tell a missing latch check apart from a protection refusal.
- **Busy:** commands issued while busy show whether the busy flag gates enable and disable as well as writes.
- **Pin:** pin toggling around enable strobes separates the two schemes. Writes with protect-enable set and then cleared show whether the pin guards status writes only.
- **Status data:** status writes carrying junk bits, and done pulses while idle, expose premature or unmasked commits.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_WRSR  = 3'd3,
    OP_WRITE = 3'd4
  } op_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nv_cfg_t;

  typedef struct packed {
    logic arr_grant;
    logic arr_block;
    logic sr_grant;
    logic sr_block;
    logic set_wel;
    logic clr_wel;
    logic start_wip;
    logic load_pend;
  } verdict_t;

endpackage

// File: rtl/eewp_cmd_arb.sv
module eewp_cmd_arb
  import eewp_pkg::*;
(
  input  logic cmd_wren_i,
  input  logic cmd_wrdi_i,
  input  logic cmd_wrsr_i,
  input  logic cmd_write_i,
  output op_e  op_o
);

  // Fixed priority: array write, status write, disable, enable.
  always_comb begin
    if (cmd_write_i) begin
      op_o = OP_WRITE;
    end else if (cmd_wrsr_i) begin
      op_o = OP_WRSR;
    end else if (cmd_wrdi_i) begin
      op_o = OP_WRDI;
    end else if (cmd_wren_i) begin
      op_o = OP_WREN;
    end else begin
      op_o = OP_NONE;
    end
  end

endmodule

// File: rtl/eewp_bp_decode.sv
module eewp_bp_decode
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  localparam int MSB = ADDR_W - 1;

  logic [1:0] region;   // which quarter of the array the address falls in
  logic [2:0] thresh;   // lowest protected quarter, 4 means none

  assign region = addr_i[MSB -: 2];

  always_comb begin
    unique case (prot_e'(bp_i))
      PROT_NONE: thresh = 3'd4;
      PROT_QTR:  thresh = 3'd3;
      PROT_HALF: thresh = 3'd2;
      PROT_ALL:  thresh = 3'd0;
      default:   thresh = 3'd4;
    endcase
  end

  assign hit_o = ({1'b0, region} >= thresh);

endmodule

// File: rtl/eewp_guard.sv
module eewp_guard
  import eewp_pkg::*;
#(
  parameter bit SMALL_DEV = 1'b0
) (
  input  op_e      op_i,
  input  logic     wip_i,
  input  logic     wel_i,
  input  logic     wpen_i,
  input  logic     wp_ni,
  input  logic     bp_hit_i,
  output verdict_t verdict_o
);

  logic wel_eff;   // latch value as seen by this cycle's decision
  logic set_ok;    // latch may be set this cycle
  logic sr_lock;   // pin currently guards the status byte

  generate
    if (SMALL_DEV) begin : g_small
      logic unused_wpen;
      assign unused_wpen = wpen_i;
      assign wel_eff     = wel_i & wp_ni;
      assign set_ok      = wp_ni;
      assign sr_lock     = 1'b0;
    end else begin : g_large
      assign wel_eff = wel_i;
      assign set_ok  = 1'b1;
      assign sr_lock = wpen_i & ~wp_ni;
    end
  endgenerate

  always_comb begin
    verdict_o = '0;
    unique case (op_i)
      OP_WREN: begin
        verdict_o.set_wel = ~wip_i & set_ok;
      end
      OP_WRDI: begin
        verdict_o.clr_wel = ~wip_i;
      end
      OP_WRSR: begin
        if (wip_i || !wel_eff || sr_lock) begin
          verdict_o.sr_block = 1'b1;
        end else begin
          verdict_o.sr_grant  = 1'b1;
          verdict_o.start_wip = 1'b1;
          verdict_o.load_pend = 1'b1;
        end
      end
      OP_WRITE: begin
        if (wip_i || !wel_eff || bp_hit_i) begin
          verdict_o.arr_block = 1'b1;
        end else begin
          verdict_o.arr_grant = 1'b1;
          verdict_o.start_wip = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/eewp_status_regs.sv
module eewp_status_regs
  import eewp_pkg::*;
#(
  parameter bit SMALL_DEV = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  verdict_t          verdict_i,
  input  nv_cfg_t           wr_cfg_i,
  input  logic              wp_ni,
  input  logic              wcyc_done_i,
  input  logic              cmd_rdsr_i,
  output logic              wip_o,
  output logic              wel_o,
  output nv_cfg_t           cfg_o,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] rd_status_o,
  output logic              arr_grant_o,
  output logic              arr_block_o,
  output logic              sr_grant_o,
  output logic              sr_block_o
);

  localparam bit PIN_GATES_WEL = SMALL_DEV;

  logic              wip_q, wip_d;
  logic              wel_q, wel_d;
  nv_cfg_t           cfg_q;
  nv_cfg_t           pend_q;
  logic              pend_sr_q, pend_sr_d;
  logic [STAT_W-1:0] rd_q;
  logic [3:0]        pulse_q, pulse_d;
  logic [STAT_W-1:0] status;

  logic done_ok;
  logic cfg_en;
  logic pend_en;
  logic pend_sr_en;
  logic rd_en;

  assign done_ok    = wcyc_done_i & wip_q;
  assign cfg_en     = done_ok & pend_sr_q;
  assign pend_en    = verdict_i.load_pend;
  assign pend_sr_en = verdict_i.start_wip | done_ok;
  assign rd_en      = cmd_rdsr_i;

  assign status = {cfg_q.wpen, 3'b000, cfg_q.bp, wel_q, wip_q};

  // Next-state logic.
  always_comb begin
    wip_d = wip_q;
    if (verdict_i.start_wip) begin
      wip_d = 1'b1;
    end else if (done_ok) begin
      wip_d = 1'b0;
    end

    wel_d = wel_q;
    if (verdict_i.set_wel) begin
      wel_d = 1'b1;
    end
    if (verdict_i.clr_wel || done_ok) begin
      wel_d = 1'b0;
    end
    if (PIN_GATES_WEL && !wp_ni) begin
      wel_d = 1'b0;
    end

    pend_sr_d = verdict_i.load_pend;
    pulse_d   = {verdict_i.arr_grant, verdict_i.arr_block,
                 verdict_i.sr_grant,  verdict_i.sr_block};
  end

  // Registers.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_q     <= 1'b0;
      wel_q     <= 1'b0;
      cfg_q     <= '0;
      pend_q    <= '0;
      pend_sr_q <= 1'b0;
      rd_q      <= '0;
      pulse_q   <= '0;
    end else begin
      wip_q   <= wip_d;
      wel_q   <= wel_d;
      pulse_q <= pulse_d;
      if (cfg_en) begin
        cfg_q <= pend_q;
      end
      if (pend_en) begin
        pend_q <= wr_cfg_i;
      end
      if (pend_sr_en) begin
        pend_sr_q <= pend_sr_d;
      end
      if (rd_en) begin
        rd_q <= status;
      end
    end
  end

  assign wip_o       = wip_q;
  assign wel_o       = wel_q;
  assign cfg_o       = cfg_q;
  assign status_o    = status;
  assign rd_status_o = rd_q;
  assign arr_grant_o = pulse_q[3];
  assign arr_block_o = pulse_q[2];
  assign sr_grant_o  = pulse_q[1];
  assign sr_block_o  = pulse_q[0];

  // R5
  wip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_q && !wcyc_done_i |=> wip_q);

  // R5
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_q && wcyc_done_i |=> !wip_q && !wel_q);

  // R6
  cfg_only_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wip_q && wcyc_done_i) |=> $stable(cfg_q));

  // R11
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wip_q && wcyc_done_i && !verdict_i.start_wip |=> !wip_q);

  generate
    if (SMALL_DEV) begin : g_small_chk
      // R9
      pin_low_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wp_ni |=> !wel_q);
      // R9
      wpen_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_q.wpen);
    end
  endgenerate

endmodule

// File: rtl/eewp_ctrl.sv
module eewp_ctrl
  import eewp_pkg::*;
#(
  parameter bit SMALL_DEV = 1'b0,
  parameter int ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              cmd_rdsr_i,
  input  logic              wp_ni,
  input  logic              wcyc_done_i,
  output logic [7:0]        status_o,
  output logic [7:0]        rd_status_o,
  output logic              arr_grant_o,
  output logic              arr_block_o,
  output logic              sr_grant_o,
  output logic              sr_block_o
);

  op_e      op;
  verdict_t verdict;
  nv_cfg_t  cfg;
  nv_cfg_t  wr_cfg;
  logic     wip;
  logic     wel;
  logic     bp_hit;
  logic     unused_sr_bits;

  assign unused_sr_bits = ^{sr_wdata_i[7], sr_wdata_i[6:4], sr_wdata_i[1:0]};

  generate
    if (SMALL_DEV) begin : g_cfg_small
      assign wr_cfg = '{wpen: 1'b0, bp: sr_wdata_i[3:2]};
    end else begin : g_cfg_large
      assign wr_cfg = '{wpen: sr_wdata_i[7], bp: sr_wdata_i[3:2]};
    end
  endgenerate

  eewp_cmd_arb u_arb (
    .cmd_wren_i  (cmd_wren_i),
    .cmd_wrdi_i  (cmd_wrdi_i),
    .cmd_wrsr_i  (cmd_wrsr_i),
    .cmd_write_i (cmd_write_i),
    .op_o        (op)
  );

  eewp_bp_decode #(.ADDR_W(ADDR_W)) u_bp (
    .bp_i   (cfg.bp),
    .addr_i (wr_addr_i),
    .hit_o  (bp_hit)
  );

  eewp_guard #(.SMALL_DEV(SMALL_DEV)) u_guard (
    .op_i      (op),
    .wip_i     (wip),
    .wel_i     (wel),
    .wpen_i    (cfg.wpen),
    .wp_ni     (wp_ni),
    .bp_hit_i  (bp_hit),
    .verdict_o (verdict)
  );

  eewp_status_regs #(.SMALL_DEV(SMALL_DEV)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .verdict_i   (verdict),
    .wr_cfg_i    (wr_cfg),
    .wp_ni       (wp_ni),
    .wcyc_done_i (wcyc_done_i),
    .cmd_rdsr_i  (cmd_rdsr_i),
    .wip_o       (wip),
    .wel_o       (wel),
    .cfg_o       (cfg),
    .status_o    (status_o),
    .rd_status_o (rd_status_o),
    .arr_grant_o (arr_grant_o),
    .arr_block_o (arr_block_o),
    .sr_grant_o  (sr_grant_o),
    .sr_block_o  (sr_block_o)
  );

  // R3
  start_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(status_o[1]));

  // R8
  busy_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && (cmd_write_i || cmd_wrsr_i) |=> !arr_grant_o && !sr_grant_o);

  // R4
  bp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_write_i && !status_o[0] && status_o[1] && bp_hit |=> arr_block_o && status_o[1]);

  generate
    if (!SMALL_DEV) begin : g_large_chk
      // R10
      pin_guards_sr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[7] && !wp_ni && cmd_wrsr_i && !cmd_write_i |=> sr_block_o);
    end
  endgenerate

endmodule

// File: tb/eewp_ctrl_tb_top.sv
module eewp_ctrl_tb_top;

  localparam int AW = 6;

  logic clk;
  logic rst_n;
  logic wren [2];
  logic wrdi [2];
  logic wrsr [2];
  logic wr   [2];
  logic rdsr [2];
  logic done [2];
  logic wpn  [2];
  logic [7:0]    srd  [2];
  logic [AW-1:0] addr [2];
  logic [7:0]    st   [2];
  logic [7:0]    rdd  [2];
  logic ag [2];
  logic ab [2];
  logic sg [2];
  logic sb [2];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // index 0: large-device scheme, index 1: small-device scheme
  eewp_ctrl #(.SMALL_DEV(1'b0), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_wren_i(wren[0]), .cmd_wrdi_i(wrdi[0]), .cmd_wrsr_i(wrsr[0]),
    .sr_wdata_i(srd[0]), .cmd_write_i(wr[0]), .wr_addr_i(addr[0]),
    .cmd_rdsr_i(rdsr[0]), .wp_ni(wpn[0]), .wcyc_done_i(done[0]),
    .status_o(st[0]), .rd_status_o(rdd[0]),
    .arr_grant_o(ag[0]), .arr_block_o(ab[0]), .sr_grant_o(sg[0]), .sr_block_o(sb[0])
  );

  eewp_ctrl #(.SMALL_DEV(1'b1), .ADDR_W(AW)) dut_s (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_wren_i(wren[1]), .cmd_wrdi_i(wrdi[1]), .cmd_wrsr_i(wrsr[1]),
    .sr_wdata_i(srd[1]), .cmd_write_i(wr[1]), .wr_addr_i(addr[1]),
    .cmd_rdsr_i(rdsr[1]), .wp_ni(wpn[1]), .wcyc_done_i(done[1]),
    .status_o(st[1]), .rd_status_o(rdd[1]),
    .arr_grant_o(ag[1]), .arr_block_o(ab[1]), .sr_grant_o(sg[1]), .sr_block_o(sb[1])
  );

  task automatic check(input string req, input int m, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d actual=%0h expected=%0h", req, m, act, exp);
    end
  endtask

  // k: 0 enable, 1 disable, 2 status write, 3 array write, 4 read status, 5 done
  task automatic pulse(input int m, input int k);
    @(negedge clk);
    case (k)
      0: wren[m] = 1'b1;
      1: wrdi[m] = 1'b1;
      2: wrsr[m] = 1'b1;
      3: wr[m]   = 1'b1;
      4: rdsr[m] = 1'b1;
      default: done[m] = 1'b1;
    endcase
    @(negedge clk);
    wren[m] = 1'b0; wrdi[m] = 1'b0; wrsr[m] = 1'b0;
    wr[m] = 1'b0; rdsr[m] = 1'b0; done[m] = 1'b0;
  endtask

  task automatic set_sr(input int m, input logic [7:0] d);
    pulse(m, 0);
    srd[m] = d;
    pulse(m, 2);
    pulse(m, 5);
  endtask

  function automatic logic prot_hit(input int bp, input int a);
    case (bp)
      1: return a >= 48;
      2: return a >= 32;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_mode(input int m);
    logic [7:0] keep;
    // R1 reset state
    check("R1 status", m, st[m], 8'h00);
    check("R1 rd_status", m, rdd[m], 8'h00);
    check("R1 pulses", m, {ag[m], ab[m], sg[m], sb[m]}, 4'h0);
    // R3 writes with latch clear
    addr[m] = '0;
    pulse(m, 3);
    check("R3 arr_block", m, {ag[m], ab[m]}, 2'b01);
    check("R3 status", m, st[m], 8'h00);
    srd[m] = 8'h0C;
    pulse(m, 2);
    check("R3 sr_block", m, {sg[m], sb[m]}, 2'b01);
    check("R3 status sr", m, st[m], 8'h00);
    // R2 / R7
    pulse(m, 0);
    check("R2 wel set", m, st[m], 8'h02);
    pulse(m, 1);
    check("R7 wel clear", m, st[m], 8'h00);
    // R11 idle done
    pulse(m, 5);
    check("R11 idle done", m, st[m], 8'h00);
    // R6 junk bits ignored, deferred commit
    pulse(m, 0);
    srd[m] = (m == 0) ? 8'h7F : 8'hFF;
    pulse(m, 2);
    check("R6 sr_grant", m, {sg[m], sb[m]}, 2'b10);
    check("R6 busy pre-commit", m, st[m], 8'h03);
    pulse(m, 5);
    check("R6 commit", m, st[m], 8'h0C);
    // protection sweep: R4 / R5 / R8 / R12
    for (int bp = 0; bp < 4; bp++) begin
      set_sr(m, 8'(bp << 2));
      check("R6 bp set", m, st[m], 8'(bp << 2));
      for (int a = 0; a < 64; a++) begin
        logic hit;
        hit = prot_hit(bp, a);
        pulse(m, 0);
        addr[m] = AW'(a);
        pulse(m, 3);
        check("R4 decision", m, {ag[m], ab[m]}, hit ? 2'b01 : 2'b10);
        if (hit) begin
          check("R4 wel kept", m, st[m], 8'((bp << 2) | 2));
          pulse(m, 1);
        end else begin
          check("R5 busy+wel", m, st[m], 8'((bp << 2) | 3));
          if (a == 5) begin
            keep = st[m];
            pulse(m, 1);
            check("R8 wrdi ignored", m, st[m], keep);
            pulse(m, 3);
            check("R8 write blocked", m, {ag[m], ab[m]}, 2'b01);
            srd[m] = 8'h00;
            pulse(m, 2);
            check("R8 sr blocked", m, {sg[m], sb[m], st[m]}, {2'b01, keep});
            pulse(m, 4);
            check("R12 read while busy", m, rdd[m], keep);
          end
          pulse(m, 5);
          check("R5 done clears", m, st[m], 8'(bp << 2));
        end
      end
    end
    set_sr(m, 8'h00);
    check("R6 bp clear", m, st[m], 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) begin
      wren[m] = 0; wrdi[m] = 0; wrsr[m] = 0; wr[m] = 0; rdsr[m] = 0;
      done[m] = 0; wpn[m] = 1; srd[m] = '0; addr[m] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_mode(0);
    run_mode(1);
    // R9 small-device pin behaviour
    pulse(1, 0);
    check("R9 wel set", 1, st[1], 8'h02);
    wpn[1] = 1'b0;
    @(negedge clk);
    check("R9 pin clears", 1, st[1], 8'h00);
    pulse(1, 0);
    check("R9 set held off", 1, st[1], 8'h00);
    wpn[1] = 1'b1;
    @(negedge clk);
    check("R9 no re-set", 1, st[1], 8'h00);
    pulse(1, 0);
    check("R9 set after rise", 1, st[1], 8'h02);
    pulse(1, 1);
    // R10 large-device pin behaviour
    wpn[0] = 1'b0;
    pulse(0, 0);
    check("R10 wel unaffected", 0, st[0], 8'h02);
    srd[0] = 8'h80;
    pulse(0, 2);
    check("R10 pin ignored wpen0", 0, {sg[0], sb[0]}, 2'b10);
    pulse(0, 5);
    check("R10 wpen set", 0, st[0], 8'h80);
    pulse(0, 0);
    srd[0] = 8'h00;
    pulse(0, 2);
    check("R10 sr locked", 0, {sg[0], sb[0], st[0]}, {2'b01, 8'h82});
    addr[0] = '0;
    pulse(0, 3);
    check("R10 array unaffected", 0, {ag[0], ab[0]}, 2'b10);
    pulse(0, 5);
    wpn[0] = 1'b1;
    pulse(0, 0);
    pulse(0, 2);
    check("R10 unlocked pin high", 0, {sg[0], sb[0]}, 2'b10);
    pulse(0, 5);
    check("R10 wpen cleared", 0, st[0], 8'h00);
    pulse(0, 4);
    check("R12 read idle", 0, rdd[0], 8'h00);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule